// File: doc/BRIEF.md
# Configurable Timer with Prescaler

This block is a counter that advances either on a one-cycle tick from the core's instruction clock or on edges of an external input pin. The pin can be set to count rising or falling edges. The counter can be 8 or 16 bits wide. Between the chosen source and the counter sits a power-of-two prescaler, which can be bypassed. When the counter wraps to zero, a sticky overflow flag is set.

Software reaches the block through a small byte-wide register port. There is a control byte, the live low byte of the counter, a high-byte buffer, and the flag. The counter's true high byte is never read or written directly; all access goes through the buffer:

- Reading the low byte copies the true high byte into the buffer, so a 16-bit value read low byte first is always consistent.
- Writing the low byte loads the buffer into the true high byte in the same cycle.
- Writing the low byte also clears the prescaler and suppresses the next two counting events.

Top module: `cfg_timer`

## Requirements
- R1: Control byte bit 7 (run) set to 0 stops counting: source events are then ignored and the counter value holds.
- R2: Control bit 5 selects the source: 0 means a cycle where `cyc_tick` is high, and 1 means an edge of `ext_clk_in` after a two-stage synchronizer. Control bit 4 selects the edge: 0 for rising, 1 for falling.
- R3: Control bit 6 set to 1 gives 8-bit mode: only the low byte counts, FFh goes to 00h, and the high byte is left alone. Set to 0, the full 16-bit value counts, carrying from the low byte into the high byte.
- R4: A write to the low byte (address 1) loads the counter, then suppresses the next two counting events. The third event increments.
- R5: A read of the low byte (address 1) returns the live low byte, and at the same clock edge copies the counter's true high byte into the buffer. The buffer is read back at address 2.
- R6: A write to the low byte sets the counter to {buffer, written byte} in one step. A write to address 2 changes only the buffer.
- R7: The overflow flag, on `ovf_irq` and in bit 0 of address 3, is set by a counting event that wraps FFh→00h in 8-bit mode or FFFFh→0000h in 16-bit mode.
- R8: After reset, the control byte (address 0) reads FFh, the buffer reads 00h and the flag is 0.
- R9: Once set, the flag stays set until any write to address 3 clears it.
- R10: Control bit 3 set to 1 bypasses the prescaler. Set to 0, bits 2:0 (code k) pass one counting event per 2^(k+1) source events. A low-byte write clears the prescaler count without changing these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Internal instruction-cycle strobe |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 low byte, 2 high buffer, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is the prescaler at its largest ratio combined with the post-write stall. Two whole divided periods are swallowed before the first visible increment, so the counter shows nothing for hundreds of source events. The bench drives `cyc_tick` only in counted pulses while the register port is idle, so the number of source events is exactly known. It sweeps every ratio code and checks the counter against floor(pulses / 2^(k+1)) − 2. A write made mid-period, followed by a pulse count whose result differs depending on whether the prescaler was cleared, exposes a prescaler that keeps its count across the write.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;
    localparam int RATIO_W = 3;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HBUF = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    typedef struct packed {
        logic               run;
        logic               narrow;
        logic               src_ext;
        logic               fall_edge;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
    } tmr_ctl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } es_state_t;

    es_state_t st_d, st_q;
    logic      last;

    assign last = st_q.sync[STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_evt = fall_sel ? (st_q.prev & ~last) : (~st_q.prev & last);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_evt,
    input  logic               clear,
    input  logic               bypass,
    input  logic [RATIO_W-1:0] ratio,
    output logic               cnt_evt
);
    localparam int PSC_W = 1 << RATIO_W;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } ps_state_t;

    ps_state_t        st_d, st_q;
    logic [RATIO_W:0] shamt;
    logic [PSC_W-1:0] lim;
    logic             hit;

    always_comb begin
        shamt = {1'b0, ratio} + 1'b1;
        lim   = ~({PSC_W{1'b1}} << shamt);
        hit   = ((st_q.psc & lim) == lim);
        st_d  = st_q;
        if (clear) begin
            st_d.psc = '0;
        end else if (src_evt && !bypass) begin
            st_d.psc = st_q.psc + 1'b1;
        end
        if (clear)       cnt_evt = 1'b0;
        else if (bypass) cnt_evt = src_evt;
        else             cnt_evt = src_evt & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_evt,
    input  logic          narrow,
    input  logic [DW-1:0] wdata,
    input  logic          ld_lo,
    input  logic          hbuf_wr,
    input  logic          snap,
    input  logic          flag_clr,
    output logic [2*DW-1:0] cnt,
    output logic [DW-1:0] hbuf,
    output logic          flag
);
    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] hbuf;
        logic [1:0]    inh;
        logic          flag;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (ld_lo) begin
            st_d.cnt = {st_q.hbuf, wdata};
            st_d.inh = 2'd2;
        end else if (cnt_evt) begin
            if (st_q.inh != 2'd0) begin
                st_d.inh = st_q.inh - 2'd1;
            end else if (narrow) begin
                st_d.cnt[DW-1:0] = st_q.cnt[DW-1:0] + 1'b1;
                wrap = (st_q.cnt[DW-1:0] == {DW{1'b1}});
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap = (st_q.cnt == {CW{1'b1}});
            end
        end
        if (hbuf_wr)   st_d.hbuf = wdata;
        else if (snap) st_d.hbuf = st_q.cnt[CW-1:DW];
        st_d.flag = wrap | (st_q.flag & ~flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign hbuf = st_q.hbuf;
    assign flag = st_q.flag;
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
    import cfg_timer_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_tick,
    input  logic          ext_clk_in,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          ovf_irq
);
    localparam int CTL_W = $bits(tmr_ctl_t);

    typedef struct packed {
        tmr_ctl_t ctl;
    } top_state_t;

    top_state_t    st_d, st_q;
    logic          edge_evt, src_evt, cnt_evt;
    logic          wr_ctl, wr_lo, wr_hbuf, wr_flag, rd_lo;
    logic [2*DW-1:0] cnt_w;
    logic [DW-1:0] hbuf_w;
    logic          narrow_w;

    always_comb begin
        wr_ctl  = bus_wr && (bus_addr == ADDR_CTL);
        wr_lo   = bus_wr && (bus_addr == ADDR_LO);
        wr_hbuf = bus_wr && (bus_addr == ADDR_HBUF);
        wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
        rd_lo   = bus_rd && (bus_addr == ADDR_LO);
        st_d    = st_q;
        if (wr_ctl) st_d.ctl = tmr_ctl_t'(bus_wdata[CTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctl <= tmr_ctl_t'({CTL_W{1'b1}});
        else        st_q     <= st_d;
    end

    assign narrow_w = st_q.ctl.narrow;
    assign src_evt  = st_q.ctl.run & (st_q.ctl.src_ext ? edge_evt : cyc_tick);

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_clk_in),
        .fall_sel (st_q.ctl.fall_edge),
        .edge_evt (edge_evt)
    );

    tmr_prescaler #(.RATIO_W(RATIO_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .clear   (wr_lo),
        .bypass  (st_q.ctl.bypass),
        .ratio   (st_q.ctl.ratio),
        .cnt_evt (cnt_evt)
    );

    tmr_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_evt  (cnt_evt),
        .narrow   (narrow_w),
        .wdata    (bus_wdata),
        .ld_lo    (wr_lo),
        .hbuf_wr  (wr_hbuf),
        .snap     (rd_lo),
        .flag_clr (wr_flag),
        .cnt      (cnt_w),
        .hbuf     (hbuf_w),
        .flag     (ovf_irq)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTL:  bus_rdata = DW'(st_q.ctl);
            ADDR_LO:   bus_rdata = cnt_w[DW-1:0];
            ADDR_HBUF: bus_rdata = hbuf_w;
            default:   bus_rdata = {{(DW-1){1'b0}}, ovf_irq};
        endcase
    end
endmodule

// File: rtl/cfg_timer_chk.sv
module cfg_timer_chk
    import cfg_timer_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [1:0]      bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [2*DW-1:0] cnt,
    input logic [DW-1:0]   hbuf,
    input logic            flag,
    input logic            narrow
);
    logic wr_lo_c, rd_lo_c, wr_flag_c, wr_hbuf_c;
    assign wr_lo_c   = bus_wr && (bus_addr == ADDR_LO);
    assign rd_lo_c   = bus_rd && (bus_addr == ADDR_LO);
    assign wr_flag_c = bus_wr && (bus_addr == ADDR_FLAG);
    assign wr_hbuf_c = bus_wr && (bus_addr == ADDR_HBUF);

    AST_LOAD_JOINED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_c |=> cnt == {$past(hbuf), $past(bus_wdata)}); // R6

    AST_STALL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_c ##1 !wr_lo_c |=> $stable(cnt)); // R4

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_c && !wr_hbuf_c) |=> hbuf == $past(cnt[2*DW-1:DW])); // R5

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo_c |=> (cnt == $past(cnt)) ||
                     ($past(narrow) && cnt == {$past(cnt[2*DW-1:DW]), $past(cnt[DW-1:0]) + {{(DW-1){1'b0}}, 1'b1}}) ||
                     (!$past(narrow) && cnt == $past(cnt) + {{(2*DW-1){1'b0}}, 1'b1})); // R3

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cnt[DW-1:0]) == {DW{1'b1}}); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_flag_c) |=> flag); // R9
endmodule

bind cfg_timer cfg_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_w),
    .hbuf      (hbuf_w),
    .flag      (ovf_irq),
    .narrow    (narrow_w)
);

// File: tb/cfg_timer_bench.sv
`timescale 1ns/1ps
module cfg_timer_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_tick = 1'b0;
    logic          ext_clk_in = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ovf_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cfg_timer u_cfg_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick   (cyc_tick),
        .ext_clk_in (ext_clk_in),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ovf_irq    (ovf_irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            cyc_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pin_cycle(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; idle(5);
            ext_clk_in = 1'b0; idle(5);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v;
        int d;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R8 reset values
        rd(2'd0, v); check("R8 control reset", v, 8'hFF);
        rd(2'd2, v); check("R8 buffer reset", v, 0);
        rd(2'd3, v); check("R8 flag reset", v, 0);
        check("R8 ovf_irq reset", int'(ovf_irq), 0);

        // R10 prescaler sweep over every ratio code
        for (int r = 0; r < 8; r++) begin
            d = 2 << r;
            wr(2'd0, 8'hC0 | 8'(r));
            wr(2'd1, 8'h00);
            pulses(5 * d - 1);
            rd(2'd1, v);
            check($sformatf("R10 ratio code %0d", r), v, 2);
        end

        // R10 prescaler cleared by low write (ratio code 1, divide by 4)
        wr(2'd0, 8'hC1);
        wr(2'd1, 8'h00);
        pulses(3);
        wr(2'd1, 8'h20);
        pulses(10);
        rd(2'd1, v); check("R10 prescaler clear on write", v, 8'h20);
        pulses(2);
        rd(2'd1, v); check("R10 first increment after clear", v, 8'h21);

        // R10 bypass, R4 two-event stall
        wr(2'd0, 8'hC8);
        wr(2'd1, 8'h80);
        pulses(1); rd(2'd1, v); check("R4 first event suppressed", v, 8'h80);
        pulses(1); rd(2'd1, v); check("R4 second event suppressed", v, 8'h80);
        pulses(1); rd(2'd1, v); check("R4 third event counts", v, 8'h81);
        pulses(4); rd(2'd1, v); check("R10 bypass one per event", v, 8'h85);

        // R1 run cleared
        wr(2'd0, 8'h48);
        pulses(6); rd(2'd1, v); check("R1 stopped holds value", v, 8'h85);
        wr(2'd0, 8'hC8);
        pulses(1); rd(2'd1, v); check("R1 restart counts", v, 8'h86);

        // R6 / R5 / R3 16-bit carry and buffered high byte
        wr(2'd0, 8'h88);
        wr(2'd2, 8'hAB);
        rd(2'd2, v); check("R6 buffer write only", v, 8'hAB);
        wr(2'd1, 8'hFE);
        pulses(3);
        rd(2'd1, v); check("R6 loaded low byte counted", v, 8'hFF);
        rd(2'd2, v); check("R5 snapshot after low read", v, 8'hAB);
        pulses(1);
        rd(2'd2, v); check("R5 buffer unchanged until low read", v, 8'hAB);
        rd(2'd1, v); check("R3 16-bit low wraps", v, 8'h00);
        rd(2'd2, v); check("R3 16-bit carry into high", v, 8'hAC);
        check("R7 no flag without full wrap", int'(ovf_irq), 0);

        // R3 / R7 8-bit wrap leaves high byte
        wr(2'd0, 8'hC8);
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFF);
        pulses(2);
        check("R7 flag clear before wrap", int'(ovf_irq), 0);
        pulses(1);
        check("R7 flag set on 8-bit wrap", int'(ovf_irq), 1);
        rd(2'd1, v); check("R3 8-bit low wraps", v, 8'h00);
        rd(2'd2, v); check("R3 8-bit high untouched", v, 8'h12);
        pulses(3);
        rd(2'd3, v); check("R9 flag sticky", v, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R9 flag cleared by write", v, 0);

        // R7 16-bit wrap
        wr(2'd0, 8'h88);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFF);
        pulses(3);
        check("R7 flag set on 16-bit wrap", int'(ovf_irq), 1);
        rd(2'd1, v); check("R7 16-bit wrap low", v, 0);
        rd(2'd2, v); check("R7 16-bit wrap high", v, 0);
        wr(2'd3, 8'h00);

        // R2 external source, rising edge
        wr(2'd0, 8'hE8);
        wr(2'd1, 8'h00);
        pin_cycle(2);
        pulses(4);
        rd(2'd1, v); check("R2 internal tick ignored in external mode", v, 0);
        ext_clk_in = 1'b1; idle(5);
        rd(2'd1, v); check("R2 rising edge counted", v, 1);
        ext_clk_in = 1'b0; idle(5);
        rd(2'd1, v); check("R2 falling edge ignored in rising mode", v, 1);

        // R2 external source, falling edge
        wr(2'd0, 8'hF8);
        wr(2'd1, 8'h00);
        pin_cycle(2);
        ext_clk_in = 1'b1; idle(5);
        rd(2'd1, v); check("R2 rising edge ignored in falling mode", v, 0);
        ext_clk_in = 1'b0; idle(5);
        rd(2'd1, v); check("R2 falling edge counted", v, 1);
        pin_cycle(3);
        rd(2'd1, v); check("R2 falling edges accumulate", v, 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule